// File: doc/BRIEF.md
# I2C Command Queue Sequencer

This block runs small I2C transaction programs for one bus master. The host fills two word queues, a large one and a small one, with 32-bit command words. It programs how many words a queue should run and then sets that queue's bit in a shared start word. The sequencer walks the queue from its first word and decodes each command. A command can set the slave address, send a burst of payload bytes carried inline in the queue, read a burst of bytes, or raise a report event. Every other opcode is skipped.

Each bus byte is handed to a separate bit-timing engine through a request/acknowledge handshake. The engine lies outside this block. Read bytes are packed into a small word buffer that the host drains, and the sequencer signals when a read has finished. A queue's word count returns to zero when the queue finishes running, and a halt input aborts everything.

Top module: `cmdseq_top`

## Requirements
- R1: Each load strobe for a queue appends one word and increments that queue's count. Queue 0 holds 64 words and queue 1 holds 16. A load into a queue whose count equals its capacity is refused, and the count stays the same.
- R2: A start-word write with bit MASTER_ID*2+q set requests queue q of this master. Bits that belong to other masters have no effect.
- R3: A started queue runs words 0 to N-1, where N is the smaller of the programmed execute count and the queue's count. When the run ends, that queue's count is cleared to 0.
- R4: A word with opcode 1 in bits [3:0] stores bits [10:4] as the 7-bit slave address. This address is presented on the engine address output for later transfers.
- R5: A command byte with opcode 9 (write, ends with STOP) or 11 (write, no STOP) carries the byte count in bits [7:4]. The payload bytes follow it in byte order, packed little-endian four per word, and each payload byte is one engine handshake. The first byte is flagged first and the final byte is flagged last, and STOP is requested on the final byte only for opcode 9.
- R6: A word with opcode 10 (read, STOP) or 12 (read, no STOP) reads the number of bytes given in bits [7:4]. The bytes are packed little-endian into buffer words, with byte 0 of the first word reserved as zero, which gives len/4+1 words. A one-cycle read-done pulse appears once the buffer level holds that final count.
- R7: A word with opcode 8 and bit 8 set raises a one-cycle report event for the running queue. With bit 8 clear, no event is raised.
- R8: Opcodes 0, 2 to 7 and 13 to 15 are no-ops. They cause no engine activity and execution moves to the next word.
- R9: A halt ends any run, drops the engine request, clears both queue counts and discards pending starts. All of this is visible one cycle later.
- R10: When both queues are requested together, queue 0 runs first. A request that arrives during a run is held and served once the run ends.
- R11: Once raised, an engine request and its address, direction and data stay unchanged until the engine acknowledges it or a halt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 2 | Per-queue load strobe |
| ld_data | input | 32 | Word to load |
| excnt_we | input | 2 | Per-queue execute-count write strobe |
| excnt_data | input | 7 | Execute word count value |
| start_we | input | 1 | Start word write strobe |
| start_bits | input | 4 | Start word, two bits per master |
| halt | input | 1 | Abort and clear |
| q0_count | output | 7 | Words currently held in queue 0 |
| q1_count | output | 5 | Words currently held in queue 1 |
| busy | output | 1 | A queue is running |
| report_evt | output | 2 | Per-queue report event pulse |
| rd_done | output | 1 | Read completion pulse |
| rdbuf_level | output | 3 | Words waiting in the read buffer |
| rdbuf_data | output | 32 | Oldest read buffer word |
| rdbuf_pop | input | 1 | Remove the oldest read buffer word |
| eng_req | output | 1 | Byte request to the bit engine |
| eng_rd | output | 1 | Request is a read byte |
| eng_addr | output | 7 | Slave address |
| eng_wdata | output | 8 | Byte to send |
| eng_first | output | 1 | First byte of a transfer |
| eng_last | output | 1 | Final byte of a transfer |
| eng_stop | output | 1 | Emit STOP after this byte |
| eng_ack | input | 1 | Engine has completed the byte |
| eng_rdata | input | 8 | Byte received on a read |

## Verification
The hardest state to reach is a write whose payload runs across a word boundary and ends part-way through a word. The sequencer must drop the padding and resume at the next command word. The bench builds a six-byte no-STOP write that spans two words and follows it with a no-op and a report. If the skip over the padding is wrong, either the report goes missing or extra engine bytes appear. Halting in the middle of a long read is reached by watching for the engine request and asserting halt while the modelled engine is still holding back its acknowledge.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_Q   = 2;
    localparam int ADDR_W  = 7;
    localparam int LEN_W   = 4;
    localparam int MAX_LEN = (1 << LEN_W) - 1;

    localparam logic [3:0] OP_SETADDR  = 4'd1;
    localparam logic [3:0] OP_REPORT   = 4'd8;
    localparam logic [3:0] OP_WRITE    = 4'd9;
    localparam logic [3:0] OP_READ     = 4'd10;
    localparam logic [3:0] OP_WRITE_NS = 4'd11;
    localparam logic [3:0] OP_READ_NS  = 4'd12;

    localparam int REPORT_EN_BIT = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WR,
        S_RD,
        S_RDFLUSH,
        S_FIN
    } seq_state_e;

    function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w, input logic [1:0] lane);
        return w[{lane, 3'b000} +: 8];
    endfunction

    function automatic logic [6:0] min7(input logic [6:0] a, input logic [6:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cmdseq_store.sv
module cmdseq_store
    import cmdseq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              clr,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [CW-1:0]     count
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [CW-1:0]     cnt_q;
    logic              full;

    assign full = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ld_we && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_we && !full && !clr && !rst) begin
            mem[cnt_q[AW-1:0]] <= ld_data;
        end
    end

    assign rd_word = mem[rd_idx];
    assign count   = cnt_q;

endmodule

// File: rtl/cmdseq_rdbuf.sv
module cmdseq_rdbuf
    import cmdseq_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int LVL_W = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              byte_we,
    input  logic [7:0]        byte_in,
    input  logic              flush,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [LVL_W-1:0]  level
);

    localparam int PW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [WORD_W-1:0] buf_q [WORDS];
    logic [WORD_W-1:0] pack_q;
    logic [WORD_W-1:0] merged;
    logic [1:0]        lane_q;
    logic [LVL_W-1:0]  wp_q, rp_q;
    logic              push;

    assign merged = byte_we ? (pack_q | (WORD_W'(byte_in) << {lane_q, 3'b000})) : pack_q;
    assign push   = (byte_we && lane_q == 2'd3) || (flush && lane_q != 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pack_q <= '0;
            lane_q <= 2'd0;
            wp_q   <= '0;
            rp_q   <= '0;
        end else if (clear) begin
            pack_q <= '0;
            lane_q <= 2'd1;
            wp_q   <= '0;
            rp_q   <= '0;
        end else begin
            if (byte_we) begin
                pack_q <= (lane_q == 2'd3) ? '0 : merged;
                lane_q <= lane_q + 2'd1;
            end else if (flush) begin
                pack_q <= '0;
                lane_q <= 2'd0;
            end
            if (push && wp_q < LVL_W'(WORDS)) begin
                buf_q[wp_q[PW-1:0]] <= merged;
                wp_q <= wp_q + 1'b1;
            end
            if (pop && rp_q != wp_q) begin
                rp_q <= rp_q + 1'b1;
            end
        end
    end

    assign level = wp_q - rp_q;
    assign head  = buf_q[rp_q[PW-1:0]];

endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
    import cmdseq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_Q-1:0]  start_req,
    input  logic              halt,
    input  logic [6:0]        excnt [NUM_Q],
    input  logic [6:0]        qcnt  [NUM_Q],
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  ptr,
    output logic              sel,
    output logic [NUM_Q-1:0]  store_clr,
    output logic              busy,
    output logic [NUM_Q-1:0]  report_evt,
    output logic              rd_done,
    output logic              rb_clear,
    output logic              rb_byte_we,
    output logic              rb_flush,
    output logic              eng_req,
    output logic              eng_rd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [7:0]        eng_wdata,
    output logic              eng_first,
    output logic              eng_last,
    output logic              eng_stop,
    input  logic              eng_ack
);

    seq_state_e        state_q;
    logic              sel_q;
    logic [NUM_Q-1:0]  pend_q, pick_mask;
    logic [6:0]        ptr_q, limit_q;
    logic [1:0]        lane_q;
    logic [LEN_W-1:0]  rem_q;
    logic              first_q, stop_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NUM_Q-1:0]  rpt_q;
    logic              rd_done_q;

    logic [3:0]        op;
    logic [LEN_W-1:0]  len;
    logic              at_end, nxt_sel, is_read;

    assign op      = word[3:0];
    assign len     = word[4 +: LEN_W];
    assign at_end  = (ptr_q >= limit_q);
    assign nxt_sel = !pend_q[0];
    assign is_read = (op == OP_READ) || (op == OP_READ_NS);

    always_comb begin
        pick_mask = '0;
        if (state_q == S_IDLE && pend_q != '0) begin
            pick_mask[nxt_sel] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            sel_q     <= 1'b0;
            pend_q    <= '0;
            ptr_q     <= '0;
            limit_q   <= '0;
            lane_q    <= '0;
            rem_q     <= '0;
            first_q   <= 1'b0;
            stop_q    <= 1'b0;
            addr_q    <= '0;
            rpt_q     <= '0;
            rd_done_q <= 1'b0;
        end else begin
            rpt_q     <= '0;
            rd_done_q <= 1'b0;
            pend_q    <= (pend_q | start_req) & ~pick_mask;
            if (halt) begin
                state_q <= S_IDLE;
                pend_q  <= '0;
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        if (pend_q != '0) begin
                            sel_q   <= nxt_sel;
                            ptr_q   <= '0;
                            limit_q <= min7(excnt[nxt_sel], qcnt[nxt_sel]);
                            state_q <= S_FETCH;
                        end
                    end
                    S_FETCH: begin
                        if (at_end) begin
                            state_q <= S_FIN;
                        end else begin
                            case (op)
                                OP_SETADDR: begin
                                    addr_q <= word[4 +: ADDR_W];
                                    ptr_q  <= ptr_q + 7'd1;
                                end
                                OP_REPORT: begin
                                    rpt_q[sel_q] <= word[REPORT_EN_BIT];
                                    ptr_q        <= ptr_q + 7'd1;
                                end
                                OP_WRITE, OP_WRITE_NS: begin
                                    stop_q <= (op == OP_WRITE);
                                    if (len == '0) begin
                                        ptr_q <= ptr_q + 7'd1;
                                    end else begin
                                        lane_q  <= 2'd1;
                                        rem_q   <= len;
                                        first_q <= 1'b1;
                                        state_q <= S_WR;
                                    end
                                end
                                OP_READ, OP_READ_NS: begin
                                    stop_q  <= (op == OP_READ);
                                    ptr_q   <= ptr_q + 7'd1;
                                    rem_q   <= len;
                                    first_q <= 1'b1;
                                    state_q <= (len == '0) ? S_RDFLUSH : S_RD;
                                end
                                default: ptr_q <= ptr_q + 7'd1;
                            endcase
                        end
                    end
                    S_WR: begin
                        if (eng_ack) begin
                            first_q <= 1'b0;
                            rem_q   <= rem_q - 1'b1;
                            lane_q  <= lane_q + 2'd1;
                            if (lane_q == 2'd3 || rem_q == LEN_W'(1)) begin
                                ptr_q <= ptr_q + 7'd1;
                            end
                            if (rem_q == LEN_W'(1)) begin
                                state_q <= S_FETCH;
                            end
                        end
                    end
                    S_RD: begin
                        if (eng_ack) begin
                            first_q <= 1'b0;
                            rem_q   <= rem_q - 1'b1;
                            if (rem_q == LEN_W'(1)) begin
                                state_q <= S_RDFLUSH;
                            end
                        end
                    end
                    S_RDFLUSH: begin
                        rd_done_q <= 1'b1;
                        state_q   <= S_FETCH;
                    end
                    S_FIN: begin
                        state_q <= S_IDLE;
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        store_clr = '0;
        if (halt) begin
            store_clr = '1;
        end else if (state_q == S_FIN) begin
            store_clr[sel_q] = 1'b1;
        end
    end

    assign rb_clear   = !halt && state_q == S_FETCH && !at_end && is_read;
    assign rb_byte_we = !halt && state_q == S_RD && eng_ack;
    assign rb_flush   = !halt && state_q == S_RDFLUSH;

    assign eng_req   = (state_q == S_WR) || (state_q == S_RD);
    assign eng_rd    = (state_q == S_RD);
    assign eng_addr  = addr_q;
    assign eng_wdata = (state_q == S_WR) ? lane_byte(word, lane_q) : 8'h00;
    assign eng_first = eng_req && first_q;
    assign eng_last  = eng_req && (rem_q == LEN_W'(1));
    assign eng_stop  = eng_last && stop_q;

    assign ptr        = ptr_q[IDX_W-1:0];
    assign sel        = sel_q;
    assign busy       = (state_q != S_IDLE);
    assign report_evt = rpt_q;
    assign rd_done    = rd_done_q;

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int MASTER_ID = 0,
    parameter int Q0_DEPTH  = 64,
    parameter int Q1_DEPTH  = 16,
    parameter int START_W   = 4,
    parameter int C0_W      = $clog2(Q0_DEPTH + 1),
    parameter int C1_W      = $clog2(Q1_DEPTH + 1),
    parameter int RD_WORDS  = MAX_LEN / 4 + 1,
    parameter int LVL_W     = $clog2(RD_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_Q-1:0]   ld_we,
    input  logic [WORD_W-1:0]  ld_data,
    input  logic [NUM_Q-1:0]   excnt_we,
    input  logic [6:0]         excnt_data,
    input  logic               start_we,
    input  logic [START_W-1:0] start_bits,
    input  logic               halt,
    output logic [C0_W-1:0]    q0_count,
    output logic [C1_W-1:0]    q1_count,
    output logic               busy,
    output logic [NUM_Q-1:0]   report_evt,
    output logic               rd_done,
    output logic [LVL_W-1:0]   rdbuf_level,
    output logic [WORD_W-1:0]  rdbuf_data,
    input  logic               rdbuf_pop,
    output logic               eng_req,
    output logic               eng_rd,
    output logic [ADDR_W-1:0]  eng_addr,
    output logic [7:0]         eng_wdata,
    output logic               eng_first,
    output logic               eng_last,
    output logic               eng_stop,
    input  logic               eng_ack,
    input  logic [7:0]         eng_rdata
);

    localparam int IDX_W = $clog2((Q0_DEPTH > Q1_DEPTH) ? Q0_DEPTH : Q1_DEPTH);

    logic [NUM_Q-1:0]  start_req;
    logic [6:0]        excnt_q [NUM_Q];
    logic [6:0]        qcnt    [NUM_Q];
    logic [WORD_W-1:0] qword   [NUM_Q];
    logic [IDX_W-1:0]  ptr;
    logic              sel;
    logic [NUM_Q-1:0]  store_clr;
    logic              rb_clear, rb_byte_we, rb_flush;

    always_comb begin
        start_req = '0;
        for (int b = 0; b < START_W; b++) begin
            if ((b / 2) == MASTER_ID) begin
                start_req[b % 2] = start_req[b % 2] | (start_we & start_bits[b]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NUM_Q; q++) excnt_q[q] <= '0;
        end else begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (excnt_we[q]) excnt_q[q] <= excnt_data;
            end
        end
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : store_g
        localparam int D  = (g == 0) ? Q0_DEPTH : Q1_DEPTH;
        localparam int AW = $clog2(D);
        localparam int CW = $clog2(D + 1);
        logic [CW-1:0] cnt_w;

        cmdseq_store #(.DEPTH(D)) u_store (
            .clk     (clk),
            .rst     (rst),
            .ld_we   (ld_we[g]),
            .ld_data (ld_data),
            .clr     (store_clr[g]),
            .rd_idx  (ptr[AW-1:0]),
            .rd_word (qword[g]),
            .count   (cnt_w)
        );

        assign qcnt[g] = 7'(cnt_w);
    end

    assign q0_count = store_g[0].cnt_w;
    assign q1_count = store_g[1].cnt_w;

    cmdseq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .halt       (halt),
        .excnt      (excnt_q),
        .qcnt       (qcnt),
        .word       (qword[sel]),
        .ptr        (ptr),
        .sel        (sel),
        .store_clr  (store_clr),
        .busy       (busy),
        .report_evt (report_evt),
        .rd_done    (rd_done),
        .rb_clear   (rb_clear),
        .rb_byte_we (rb_byte_we),
        .rb_flush   (rb_flush),
        .eng_req    (eng_req),
        .eng_rd     (eng_rd),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_first  (eng_first),
        .eng_last   (eng_last),
        .eng_stop   (eng_stop),
        .eng_ack    (eng_ack)
    );

    cmdseq_rdbuf #(.WORDS(RD_WORDS), .LVL_W(LVL_W)) u_rdbuf (
        .clk     (clk),
        .rst     (rst),
        .clear   (rb_clear),
        .byte_we (rb_byte_we),
        .byte_in (eng_rdata),
        .flush   (rb_flush),
        .pop     (rdbuf_pop),
        .head    (rdbuf_data),
        .level   (rdbuf_level)
    );

endmodule

// File: rtl/cmdseq_checker.sv
module cmdseq_checker #(
    parameter int Q0_DEPTH = 64,
    parameter int Q1_DEPTH = 16,
    parameter int C0_W     = 7,
    parameter int C1_W     = 5,
    parameter int LVL_W    = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            halt,
    input logic [1:0]      ld_we,
    input logic [C0_W-1:0] q0_count,
    input logic [C1_W-1:0] q1_count,
    input logic            busy,
    input logic [1:0]      report_evt,
    input logic            rd_done,
    input logic [LVL_W-1:0] rdbuf_level,
    input logic            eng_req,
    input logic            eng_ack,
    input logic            eng_rd,
    input logic [6:0]      eng_addr,
    input logic [7:0]      eng_wdata,
    input logic            eng_last,
    input logic            eng_stop
);

    a_r1_q0_cap: assert property (@(posedge clk) disable iff (rst)
        q0_count <= C0_W'(Q0_DEPTH));

    a_r1_q0_refuse: assert property (@(posedge clk) disable iff (rst)
        (ld_we[0] && q0_count == C0_W'(Q0_DEPTH) && !halt)
        |=> (q0_count == C0_W'(Q0_DEPTH) || q0_count == '0));

    a_r1_q1_refuse: assert property (@(posedge clk) disable iff (rst)
        (ld_we[1] && q1_count == C1_W'(Q1_DEPTH) && !halt)
        |=> (q1_count == C1_W'(Q1_DEPTH) || q1_count == '0));

    a_r9_halt_clears: assert property (@(posedge clk) disable iff (rst)
        halt |=> (q0_count == '0 && q1_count == '0 && !busy && !eng_req));

    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack && !halt)
        |=> (eng_req && $stable(eng_rd) && $stable(eng_addr) && $stable(eng_wdata)));

    a_r7_one_report: assert property (@(posedge clk) disable iff (rst)
        $onehot0(report_evt));

    a_r6_done_level: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> rdbuf_level != '0);

    a_r5_stop_on_last: assert property (@(posedge clk) disable iff (rst)
        eng_stop |-> (eng_last && eng_req));

endmodule

bind cmdseq_top cmdseq_checker #(
    .Q0_DEPTH (Q0_DEPTH),
    .Q1_DEPTH (Q1_DEPTH),
    .C0_W     (C0_W),
    .C1_W     (C1_W),
    .LVL_W    (LVL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt        (halt),
    .ld_we       (ld_we),
    .q0_count    (q0_count),
    .q1_count    (q1_count),
    .busy        (busy),
    .report_evt  (report_evt),
    .rd_done     (rd_done),
    .rdbuf_level (rdbuf_level),
    .eng_req     (eng_req),
    .eng_ack     (eng_ack),
    .eng_rd      (eng_rd),
    .eng_addr    (eng_addr),
    .eng_wdata   (eng_wdata),
    .eng_last    (eng_last),
    .eng_stop    (eng_stop)
);

// File: tb/cmdseq_top_tb.sv
module cmdseq_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ld_we = '0;
    logic [31:0] ld_data = '0;
    logic [1:0]  excnt_we = '0;
    logic [6:0]  excnt_data = '0;
    logic        start_we = 1'b0;
    logic [3:0]  start_bits = '0;
    logic        halt = 1'b0;
    logic [6:0]  q0_count;
    logic [4:0]  q1_count;
    logic        busy;
    logic [1:0]  report_evt;
    logic        rd_done;
    logic [2:0]  rdbuf_level;
    logic [31:0] rdbuf_data;
    logic        rdbuf_pop = 1'b0;
    logic        eng_req, eng_rd, eng_first, eng_last, eng_stop;
    logic [6:0]  eng_addr;
    logic [7:0]  eng_wdata;
    logic        eng_ack = 1'b0;
    logic [7:0]  eng_rdata = '0;

    always #2 clk = ~clk;

    cmdseq_top u_dut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_data(ld_data),
        .excnt_we(excnt_we), .excnt_data(excnt_data),
        .start_we(start_we), .start_bits(start_bits), .halt(halt),
        .q0_count(q0_count), .q1_count(q1_count), .busy(busy),
        .report_evt(report_evt), .rd_done(rd_done),
        .rdbuf_level(rdbuf_level), .rdbuf_data(rdbuf_data), .rdbuf_pop(rdbuf_pop),
        .eng_req(eng_req), .eng_rd(eng_rd), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_first(eng_first), .eng_last(eng_last),
        .eng_stop(eng_stop), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int rpt0 = 0, rpt1 = 0, rdd = 0;
    int log_n = 0;
    int rd_ctr = 0;
    logic [7:0] lg_data  [64];
    logic [6:0] lg_addr  [64];
    logic       lg_rd    [64];
    logic       lg_first [64];
    logic       lg_last  [64];
    logic       lg_stop  [64];

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Event monitor
    initial begin
        forever begin
            @(negedge clk);
            if (report_evt[0]) rpt0++;
            if (report_evt[1]) rpt1++;
            if (rd_done) rdd++;
        end
    end

    // Bit-engine model: records each request, acknowledges after a short delay
    initial begin
        int st = 0;
        int dly = 0;
        forever begin
            @(negedge clk);
            case (st)
                0: if (eng_req && !rst) begin
                    if (log_n < 64) begin
                        lg_data[log_n]  = eng_wdata;
                        lg_addr[log_n]  = eng_addr;
                        lg_rd[log_n]    = eng_rd;
                        lg_first[log_n] = eng_first;
                        lg_last[log_n]  = eng_last;
                        lg_stop[log_n]  = eng_stop;
                    end
                    log_n++;
                    dly = 2;
                    st = 1;
                end
                1: begin
                    dly--;
                    if (dly == 0) begin
                        eng_ack   = 1'b1;
                        eng_rdata = 8'hC0 + 8'(rd_ctr);
                        rd_ctr++;
                        st = 2;
                    end
                end
                default: begin
                    eng_ack = 1'b0;
                    st = 0;
                end
            endcase
        end
    end

    task automatic load(input int q, input logic [31:0] d);
        @(negedge clk);
        ld_we = '0;
        ld_we[q] = 1'b1;
        ld_data = d;
        @(negedge clk);
        ld_we = '0;
    endtask

    task automatic set_exec(input int q, input int n);
        @(negedge clk);
        excnt_we = '0;
        excnt_we[q] = 1'b1;
        excnt_data = 7'(n);
        @(negedge clk);
        excnt_we = '0;
    endtask

    task automatic start(input logic [3:0] b);
        @(negedge clk);
        start_we = 1'b1;
        start_bits = b;
        @(negedge clk);
        start_we = 1'b0;
        start_bits = '0;
    endtask

    task automatic do_halt();
        @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        repeat (4) @(negedge clk);
        while (busy && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk);
        rdbuf_pop = 1'b1;
        @(negedge clk);
        rdbuf_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("reset q0_count", q0_count, 0);
        check("reset q1_count", q1_count, 0);
        check("reset busy", busy, 0);
        check("reset eng_req", eng_req, 0);
        check("reset rdbuf_level", rdbuf_level, 0);
        check("reset report_evt", report_evt, 0);
    endtask

    // R4 R5 R7 R3: write with STOP on queue 0
    task automatic t_write_stop();
        int base = log_n;
        int r0 = rpt0;
        load(0, 32'h0000_0521);
        load(0, 32'h3322_1139);
        load(0, 32'h0000_0108);
        check("R1 q0_count after 3 loads", q0_count, 3);
        set_exec(0, 3);
        start(4'b0001);
        wait_idle();
        check("R5 write byte count", log_n - base, 3);
        check("R5 byte0", lg_data[base], 8'h11);
        check("R5 byte1", lg_data[base+1], 8'h22);
        check("R5 byte2", lg_data[base+2], 8'h33);
        check("R4 addr", lg_addr[base], 7'h52);
        check("R5 first flag", {lg_first[base], lg_first[base+1], lg_first[base+2]}, 3'b100);
        check("R5 last flag", {lg_last[base], lg_last[base+1], lg_last[base+2]}, 3'b001);
        check("R5 stop flag", {lg_stop[base], lg_stop[base+1], lg_stop[base+2]}, 3'b001);
        check("R5 direction write", lg_rd[base], 0);
        check("R7 report q0", rpt0 - r0, 1);
        check("R3 q0 cleared at end", q0_count, 0);
    endtask

    // R5 R8: no-STOP write spanning words, then no-op, then report on queue 1
    task automatic t_write_span();
        int base = log_n;
        int r1 = rpt1;
        load(1, 32'h0000_02A1);
        load(1, 32'hA3A2_A16B);
        load(1, 32'h00A6_A5A4);
        load(1, 32'h0000_0005);
        load(1, 32'h0000_0108);
        set_exec(1, 5);
        start(4'b0010);
        wait_idle();
        check("R5 span byte count", log_n - base, 6);
        for (int i = 0; i < 6; i++) begin
            check("R5 span byte", lg_data[base+i], 8'hA1 + 8'(i));
            check("R5 no-STOP write", lg_stop[base+i], 0);
        end
        check("R5 span last", lg_last[base+5], 1);
        check("R4 addr span", lg_addr[base], 7'h2A);
        check("R8 no-op skipped, report reached", rpt1 - r1, 1);
        check("R3 q1 cleared", q1_count, 0);
    endtask

    // R6: read packing
    task automatic t_read(input int len, input logic [31:0] w0, input logic [31:0] w1, input int words);
        int base = log_n;
        int d0 = rdd;
        rd_ctr = 0;
        load(1, 32'h0000_0331);
        load(1, 32'h0000_000A | (32'(len) << 4));
        load(1, 32'h0000_0108);
        set_exec(1, 3);
        start(4'b0010);
        wait_idle();
        check("R6 read byte count", log_n - base, len);
        check("R6 read direction", lg_rd[base], 1);
        check("R6 STOP on last read", lg_stop[base+len-1], 1);
        check("R6 read-done pulse", rdd - d0, 1);
        check("R6 buffer words", rdbuf_level, words);
        check("R6 word0", rdbuf_data, w0);
        pop();
        if (words > 1) begin
            check("R6 word1", rdbuf_data, w1);
            pop();
        end
        check("R6 buffer drained", rdbuf_level, 0);
    endtask

    // R1 R9: capacity and halt
    task automatic t_capacity();
        for (int i = 0; i < 17; i++) load(1, 32'h0);
        check("R1 q1 full at 16", q1_count, 16);
        for (int i = 0; i < 65; i++) load(0, 32'h0);
        check("R1 q0 full at 64", q0_count, 64);
        do_halt();
        check("R9 halt clears q0", q0_count, 0);
        check("R9 halt clears q1", q1_count, 0);
    endtask

    // R3 R7: execute count below and above loaded count, report without enable bit
    task automatic t_exec_count();
        int base = log_n;
        int r0 = rpt0;
        load(0, 32'h0000_0008);
        load(0, 32'h0000_0108);
        load(0, 32'h0000_1119);
        set_exec(0, 2);
        start(4'b0001);
        wait_idle();
        check("R3 partial run no engine bytes", log_n - base, 0);
        check("R7 report only with bit 8", rpt0 - r0, 1);
        check("R3 q0 cleared after partial", q0_count, 0);
        load(0, 32'h0000_0108);
        set_exec(0, 10);
        start(4'b0001);
        wait_idle();
        check("R3 exec above count clamps", rpt0 - r0, 2);
        check("R3 engine idle on clamp", log_n - base, 0);
    endtask

    // R2: start bits of another master
    task automatic t_foreign_start();
        int r0 = rpt0;
        load(0, 32'h0000_0108);
        set_exec(0, 1);
        start(4'b1100);
        repeat (10) @(negedge clk);
        check("R2 foreign start ignored busy", busy, 0);
        check("R2 foreign start keeps count", q0_count, 1);
        check("R2 foreign start no report", rpt0 - r0, 0);
        do_halt();
    endtask

    // R10: simultaneous start, queue 0 first
    task automatic t_priority();
        int base = log_n;
        load(1, 32'h0000_0111);
        load(1, 32'h0000_BB19);
        load(1, 32'h0000_0108);
        load(0, 32'h0000_0221);
        load(0, 32'h0000_AA19);
        load(0, 32'h0000_0108);
        set_exec(0, 3);
        set_exec(1, 3);
        start(4'b0011);
        wait_idle();
        wait_idle();
        check("R10 two bytes", log_n - base, 2);
        check("R10 queue 0 first", lg_data[base], 8'hAA);
        check("R10 queue 0 addr", lg_addr[base], 7'h22);
        check("R10 queue 1 second", lg_data[base+1], 8'hBB);
        check("R10 queue 1 addr", lg_addr[base+1], 7'h11);
    endtask

    // R9 R11: halt during a long read
    task automatic t_halt_read();
        int d0 = rdd;
        int r1 = rpt1;
        int t = 0;
        load(1, 32'h0000_0331);
        load(1, 32'h0000_00FA);
        load(1, 32'h0000_0108);
        set_exec(1, 3);
        start(4'b0010);
        while (!eng_req && t < 100) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        check("R11 request held awaiting ack", eng_req, 1);
        @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        check("R9 request dropped", eng_req, 0);
        check("R9 busy cleared", busy, 0);
        check("R9 q1 cleared", q1_count, 0);
        repeat (20) @(negedge clk);
        check("R9 no read-done after halt", rdd - d0, 0);
        check("R9 no report after halt", rpt1 - r1, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_stop();
        t_write_span();
        t_read(5, 32'hC2C1_C000, 32'h0000_C4C3, 2);
        t_read(3, 32'hC2C1_C000, 32'h0, 1);
        t_capacity();
        t_exec_count();
        t_foreign_start();
        t_priority();
        t_halt_read();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule